// File: doc/BRIEF.md
# Serial 1101 Pattern Recognizer

The block takes one serial bit per rising clock edge and raises a flag each time the four most recent bits, oldest first, read 1101. Matches may overlap: the final 1 of one match can also be the first 1 of the next. Two recognizers run side by side on the same input.

The first recognizer is a four-state machine whose flag is a combinational function of the stored state and the live input. It therefore reports a match in the same cycle that the last bit is presented, before that bit is clocked in. The second recognizer is a five-state machine whose flag depends only on its registered state. It reports the same match one cycle later, glitch-free and without any path from the input.

An active-high asynchronous reset returns both machines to their idle state at once, whatever the clock is doing.

Top module: `pattern1101_rec`

## Requirements
- R1: `hit_mealy` is 1 while the last three sampled bits since reset are 1,1,0 and `ser_in` is currently 1. In every other case it is 0. It follows `ser_in` combinationally within the cycle.
- R2: Overlapping matches are all reported on `hit_mealy`. For example, the stream 1,1,0,1,1,0,1 gives a flag on the 4th and on the 7th bit.
- R3: Progress is kept only through a real prefix of the pattern. A run of 1s keeps the "11 seen" progress, so the stream 1,1,1,1,0,1 flags only on its last bit.
- R4: `hit_moore` is 1 for exactly the one cycle that follows the rising edge which sampled the last bit of a match. In other words, it equals the value of `hit_mealy` one cycle earlier.
- R5: Overlapping matches are all reported on `hit_moore`, each one cycle after the matching `hit_mealy` pulse.
- R6: While `rst` is 1, both flags are 0, even between clock edges and even if `ser_in` is 1. Bits sampled before reset never count toward a later match.
- R7: `hit_mealy` is 0 whenever `ser_in` is 0.
- R8: `hit_moore` is never 1 in two consecutive cycles, and `hit_mealy` is never 1 at two consecutive sampling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| hit_mealy | output | 1 | Same-cycle match flag (state and input) |
| hit_moore | output | 1 | Match flag from state only, one cycle later |

## Verification
The state-and-input flag is due in the same cycle that the last pattern bit is driven. The bench sets `ser_in` on the falling edge and samples that flag one time unit later, before the rising edge that consumes the bit. The state-only flag is due one full cycle later. It is sampled at the next falling edge, against a reference history of the bits sampled on earlier rising edges. Reset is applied between edges and both flags are checked at once, which confirms that clearing does not wait for the clock.

// File: rtl/seq_rec_pkg.sv
package seq_rec_pkg;

  localparam int MEALY_W = 2;
  localparam int MOORE_W = 3;

  // Gray-ordered codes: idle, "1", "11", "110"
  typedef enum logic [MEALY_W-1:0] {
    ML_IDLE = 2'b00,
    ML_P1   = 2'b01,
    ML_P11  = 2'b11,
    ML_P110 = 2'b10
  } mealy_st_e;

  // Same walk plus a match state; the other three codes are illegal
  typedef enum logic [MOORE_W-1:0] {
    MR_IDLE = 3'b000,
    MR_P1   = 3'b001,
    MR_P11  = 3'b011,
    MR_P110 = 3'b010,
    MR_HIT  = 3'b110
  } moore_st_e;

endpackage

// File: rtl/rec_mealy_fsm.sv
module rec_mealy_fsm
  import seq_rec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bit_in,
  output mealy_st_e state_q,
  output logic      flag
);

  mealy_st_e state_d;

  always_comb begin
    unique case (state_q)
      ML_IDLE: state_d = bit_in ? ML_P1  : ML_IDLE;
      ML_P1:   state_d = bit_in ? ML_P11 : ML_IDLE;
      ML_P11:  state_d = bit_in ? ML_P11 : ML_P110;
      ML_P110: state_d = bit_in ? ML_P1  : ML_IDLE; // match re-uses its last 1
      default: state_d = ML_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state_q <= ML_IDLE;
    else     state_q <= state_d;
  end

  // combinational: depends on the live input as well as the state
  assign flag = (state_q == ML_P110) && bit_in;

endmodule

// File: rtl/rec_moore_fsm.sv
module rec_moore_fsm
  import seq_rec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bit_in,
  output moore_st_e state_q,
  output logic      flag
);

  moore_st_e state_d;

  always_comb begin
    case (state_q)
      MR_IDLE: state_d = bit_in ? MR_P1  : MR_IDLE;
      MR_P1:   state_d = bit_in ? MR_P11 : MR_IDLE;
      MR_P11:  state_d = bit_in ? MR_P11 : MR_P110;
      MR_P110: state_d = bit_in ? MR_HIT : MR_IDLE;
      MR_HIT:  state_d = bit_in ? MR_P11 : MR_IDLE; // suffix "11" is a prefix
      default: state_d = MR_IDLE;                   // illegal code recovers
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state_q <= MR_IDLE;
    else     state_q <= state_d;
  end

  assign flag = (state_q == MR_HIT);

endmodule

// File: rtl/pattern1101_rec.sv
module pattern1101_rec
  import seq_rec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic hit_mealy,
  output logic hit_moore
);

  mealy_st_e mealy_q;
  moore_st_e moore_q;

  rec_mealy_fsm u_mealy (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (ser_in),
    .state_q (mealy_q),
    .flag    (hit_mealy)
  );

  rec_moore_fsm u_moore (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (ser_in),
    .state_q (moore_q),
    .flag    (hit_moore)
  );

endmodule

// File: rtl/pattern1101_rec_chk.sv
module pattern1101_rec_chk (
  input logic       clk,
  input logic       rst,
  input logic       ser_in,
  input logic       hit_mealy,
  input logic       hit_moore,
  input logic [1:0] mealy_st,
  input logic [2:0] moore_st
);

  p_mealy_needs_one_r7: assert property (@(posedge clk) disable iff (rst)
    hit_mealy |-> ser_in);

  p_moore_follows_r4: assert property (@(posedge clk) disable iff (rst)
    hit_mealy |=> hit_moore);

  p_moore_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
    hit_moore |-> $past(hit_mealy));

  p_moore_single_r8: assert property (@(posedge clk) disable iff (rst)
    hit_moore |=> !hit_moore);

  p_mealy_single_r8: assert property (@(posedge clk) disable iff (rst)
    hit_mealy |=> !hit_mealy);

  p_match_restarts_r2: assert property (@(posedge clk) disable iff (rst)
    hit_mealy |=> (mealy_st == 2'b01));

  p_moore_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (moore_st != 3'b100) && (moore_st != 3'b101) && (moore_st != 3'b111));

  always @(posedge clk) begin
    if (rst) begin
      p_reset_idle_r6: assert (mealy_st == 2'b00 && moore_st == 3'b000 &&
                               !hit_mealy && !hit_moore);
    end
  end

endmodule

bind pattern1101_rec pattern1101_rec_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ser_in    (ser_in),
  .hit_mealy (hit_mealy),
  .hit_moore (hit_moore),
  .mealy_st  (mealy_q),
  .moore_st  (moore_q)
);

// File: tb/pattern1101_rec_tb.sv
module pattern1101_rec_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic hit_mealy, hit_moore;

  int total = 0;
  int bad = 0;
  logic [3:0] hist = 4'b0;
  int seen = 0;

  pattern1101_rec u_dut (
    .clk       (clk),
    .rst       (rst),
    .ser_in    (ser_in),
    .hit_mealy (hit_mealy),
    .hit_moore (hit_moore)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_mealy(logic [3:0] h, int n, logic b);
    return (n >= 3) && ({h[2:0], b} == 4'b1101);
  endfunction

  function automatic logic exp_moore(logic [3:0] h, int n);
    return (n >= 4) && (h == 4'b1101);
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // drive one bit; mtag/otag name the requirement of each flag check
  task automatic push(logic b, string mtag, string otag);
    @(negedge clk);
    ser_in = b;
    #1;
    check(b ? mtag : "R7", hit_mealy, exp_mealy(hist, seen, b));
    check(otag, hit_moore, exp_moore(hist, seen));
    @(posedge clk);
    hist = {hist[2:0], b};
    seen++;
  endtask

  task automatic push_vec(logic [15:0] v, int len, string mtag, string otag);
    for (int i = len - 1; i >= 0; i--) push(v[i], mtag, otag);
  endtask

  task automatic reset_mid(logic hold_bit);
    @(negedge clk);
    ser_in = hold_bit;
    #1;
    rst = 1'b1;
    #1;
    check("R6", hit_mealy, 1'b0);
    check("R6", hit_moore, 1'b0);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    hist = 4'b0;
    seen = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state, with input held high
    ser_in = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R6", hit_mealy, 1'b0);
    check("R6", hit_moore, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    ser_in = 1'b0;

    push_vec(16'b1101, 4, "R1", "R4");
    push(1'b0, "R1", "R4");
    push_vec(16'b1101101, 7, "R2", "R5");
    push_vec(16'b00, 2, "R2", "R5");
    push_vec(16'b111101, 6, "R3", "R4");
    push_vec(16'b1001101, 7, "R3", "R4");
    push_vec(16'b11011011, 8, "R2", "R5");

    // reset after "110" with the completing 1 already on the input
    push_vec(16'b110, 3, "R1", "R4");
    reset_mid(1'b1);
    push_vec(16'b1, 1, "R6", "R6");
    push_vec(16'b10, 2, "R6", "R6");
    // reset right as a match lands on the state-only flag
    push_vec(16'b1101, 4, "R1", "R4");
    reset_mid(1'b0);
    push_vec(16'b01, 2, "R6", "R6");

    void'($urandom(32'h1101));
    for (int i = 0; i < 4000; i++) begin
      logic b;
      b = (($urandom % 4) != 0);
      push(b, "R1", "R4");
    end
    push_vec(16'b1101101, 7, "R2", "R5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule